// File: doc/BRIEF.md
# Binary-Field Inversion Sequencer

This block returns the multiplicative inverse of an element of GF(2^163). The field is built on the reduction polynomial x^163 + x^7 + x^6 + x^3 + 1. Bit i of every 163-bit vector is the coefficient of x^i.

The block raises the operand to the power 2^163 - 2. It does this with an addition chain on exponents of the form 2^e - 1: e runs 1, 2, 4, 5, 10, 20, 40, 80, 81, 162, and one more squaring finishes the job. The chain is derived from the bit pattern of m - 1, so it follows the field-size parameter. Only two working registers hold field values:
- The first register is squared in place, the required number of times.
- It is then multiplied by either the second register (the previous chain value) or the operand.
- The product is written into both registers.

One combinational squarer (one cycle per squaring) and one bit-serial multiplier (m cycles per product) do all the arithmetic. Both are plain field-operation units with no inversion-specific logic.

A caller applies the operand and pulses `start` for one cycle while the block is idle. It then holds the operand steady until `done` rises, because the operand is read again during the two "plus one" chain steps. The inverse appears on `result` when `done` goes high. A start pulse that arrives during a computation is dropped.

Top module: `gfi_inverter`

## Requirements
- R1: For any nonzero operand, once `done` is high, `result` multiplied by the operand in GF(2^163) equals 1. For the operand x (value 2), the result has bits 162, 6, 5 and 2 set and no others.
- R2: `done` is low during the 1628 rising edges that follow the edge sampling an accepted `start`. It is high after the 1629th such edge. This is 162 squarings plus 9 multiplications of 163 cycles each.
- R3: A zero operand runs the same 1629-cycle sequence and ends with `done` high and `result` equal to 0.
- R4: While `done` is high and no new `start` is accepted, `done` stays high and `result` keeps its value.
- R5: A `start` pulse that arrives while a computation is running has no effect, including a pulse on the final edge of the computation. `done` still rises at the original time, with the inverse of the original operand, and stays high afterwards.
- R6: The edge that accepts a `start` from idle clears `done`.
- R7: After reset, `done` is 0 and `result` is 0.
- R8: An operand of 1 returns 1, and an all-ones operand returns a value whose product with it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request; taken only while idle |
| operand | input | 163 | Element to invert; held from start until done |
| result | output | 163 | Inverse, valid while done is high |
| done | output | 1 | High from completion until the next accepted start |

## Verification
Two events can fall on the same edge:
- the final squaring that completes a computation, and
- an incoming `start` request.

The bench raises `start` so that it is sampled exactly on the completion edge. It then checks three things: `done` rises anyway, `result` still inverts the original operand, and `done` stays high on the following cycles, which shows the request was dropped rather than queued.

The opposite pairing is also exercised. A `start` is sampled in the first cycle `done` is high, and `done` must drop on that same edge.

// File: rtl/gfi_pkg.sv
package gfi_pkg;

    // Field size and the low part of the reduction polynomial (x^7+x^6+x^3+1)
    parameter int          FIELD_M        = 163;
    parameter logic [31:0] FIELD_POLY_LOW = 32'h0000_00C9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SQR,
        ST_MUL,
        ST_FIN
    } seq_state_t;

    typedef enum logic {
        PH_DBL,   // exponent doubles: square e times, multiply by held value
        PH_INC    // exponent plus one: square once, multiply by operand
    } chain_phase_t;

    typedef struct packed {
        logic ld;
        logic sq_en;
        logic mul_en;
        logic mul_first;
        logic mul_use_op;
        logic mul_wr;
    } seq_ctrl_t;

    function automatic int msb_index(input int n);
        int r;
        r = 0;
        for (int i = 0; i < 31; i++) begin
            if (((n >> i) & 1) == 1) r = i;
        end
        return r;
    endfunction

    // Cycles from the accepting edge until done is set
    function automatic int inv_latency(input int m);
        int n;
        int e;
        int sq;
        int mu;
        n  = m - 1;
        e  = 1;
        sq = 0;
        mu = 0;
        for (int p = msb_index(n) - 1; p >= 0; p--) begin
            sq = sq + e;
            mu = mu + 1;
            e  = 2 * e;
            if (((n >> p) & 1) == 1) begin
                sq = sq + 1;
                mu = mu + 1;
                e  = e + 1;
            end
        end
        return sq + mu * m + 1;
    endfunction

endpackage

// File: rtl/gfi_squarer.sv
module gfi_squarer #(
    parameter int             M    = gfi_pkg::FIELD_M,
    parameter logic [M-1:0]   POLY = M'(gfi_pkg::FIELD_POLY_LOW)
) (
    input  logic [M-1:0] a,
    output logic [M-1:0] y
);
    localparam int WW = 2 * M - 1;

    logic [WW-1:0] w;

    always_comb begin
        w = '0;
        for (int i = 0; i < M; i++) begin
            w[2*i] = a[i];
        end
        for (int i = WW - 1; i >= M; i--) begin
            if (w[i]) w[i-M +: M] = w[i-M +: M] ^ POLY;
        end
        y = w[M-1:0];
    end

endmodule

// File: rtl/gfi_bitser_mul.sv
module gfi_bitser_mul #(
    parameter int             M    = gfi_pkg::FIELD_M,
    parameter logic [M-1:0]   POLY = M'(gfi_pkg::FIELD_POLY_LOW),
    localparam int            IW   = $clog2(M + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          first,
    input  logic [IW-1:0] idx,
    input  logic [M-1:0]  a,
    input  logic [M-1:0]  b,
    output logic [M-1:0]  prod_next
);
    logic [M-1:0] acc_q;
    logic [M-1:0] acc_sh;

    // MSB-first: acc = acc*x mod f + b[idx]*a
    always_comb begin
        acc_sh    = {acc_q[M-2:0], 1'b0} ^ (acc_q[M-1] ? POLY : '0);
        prod_next = (first ? '0 : acc_sh) ^ (b[idx] ? a : '0);
    end

    always_ff @(posedge clk) begin
        if (rst)     acc_q <= '0;
        else if (en) acc_q <= prod_next;
    end

endmodule

// File: rtl/gfi_ctrl.sv
module gfi_ctrl
    import gfi_pkg::*;
#(
    parameter int  M  = FIELD_M,
    localparam int CW = $clog2(M + 1),
    localparam int PW = $clog2(CW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output seq_ctrl_t     ctl,
    output logic [CW-1:0] mul_idx,
    output logic          busy,
    output logic          done
);
    localparam logic [CW-1:0] NM1     = CW'(M - 1);
    localparam int            TOP_POS = msb_index(M - 1) - 1;

    seq_state_t    state_q;
    chain_phase_t  phase_q;
    logic [CW-1:0] e_q;
    logic [CW-1:0] sq_q;
    logic [CW-1:0] mc_q;
    logic [PW-1:0] pos_q;
    logic [CW-1:0] e_nx;
    logic          bit_set;

    always_comb begin
        e_nx           = (phase_q == PH_DBL) ? (e_q << 1) : (e_q + 1'b1);
        bit_set        = NM1[pos_q];
        ctl.ld         = (state_q == ST_IDLE) && start;
        ctl.sq_en      = (state_q == ST_SQR) || (state_q == ST_FIN);
        ctl.mul_en     = (state_q == ST_MUL);
        ctl.mul_first  = (mc_q == CW'(M - 1));
        ctl.mul_use_op = (phase_q == PH_INC);
        ctl.mul_wr     = (state_q == ST_MUL) && (mc_q == '0);
        mul_idx        = mc_q;
        busy           = (state_q != ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= PH_DBL;
            e_q     <= '0;
            sq_q    <= '0;
            mc_q    <= '0;
            pos_q   <= '0;
            done    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SQR;
                        phase_q <= PH_DBL;
                        e_q     <= CW'(1);
                        sq_q    <= CW'(1);
                        pos_q   <= PW'(TOP_POS);
                        done    <= 1'b0;
                    end
                end
                ST_SQR: begin
                    if (sq_q == CW'(1)) begin
                        state_q <= ST_MUL;
                        mc_q    <= CW'(M - 1);
                    end else begin
                        sq_q <= sq_q - 1'b1;
                    end
                end
                ST_MUL: begin
                    if (mc_q == '0) begin
                        e_q <= e_nx;
                        if (phase_q == PH_DBL && bit_set) begin
                            phase_q <= PH_INC;
                            sq_q    <= CW'(1);
                            state_q <= ST_SQR;
                        end else if (pos_q == '0) begin
                            state_q <= ST_FIN;
                        end else begin
                            pos_q   <= pos_q - 1'b1;
                            phase_q <= PH_DBL;
                            sq_q    <= e_nx;
                            state_q <= ST_SQR;
                        end
                    end else begin
                        mc_q <= mc_q - 1'b1;
                    end
                end
                ST_FIN: begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/gfi_inverter.sv
module gfi_inverter
    import gfi_pkg::*;
#(
    parameter int          M        = FIELD_M,
    parameter logic [31:0] POLY_LOW = FIELD_POLY_LOW,
    localparam int         CW       = $clog2(M + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [M-1:0] operand,
    output logic [M-1:0] result,
    output logic         done
);
    localparam logic [M-1:0] POLY = M'(POLY_LOW);

    seq_ctrl_t     ctl;
    logic [CW-1:0] mul_idx;
    logic          busy;
    logic [M-1:0]  wa_q;      // squared in place, holds the result
    logic [M-1:0]  wb_q;      // previous chain value
    logic [M-1:0]  sq_y;
    logic [M-1:0]  prod_next;
    logic [M-1:0]  mul_b;

    gfi_ctrl #(.M(M)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .ctl     (ctl),
        .mul_idx (mul_idx),
        .busy    (busy),
        .done    (done)
    );

    gfi_squarer #(.M(M), .POLY(POLY)) u_sqr (
        .a (wa_q),
        .y (sq_y)
    );

    assign mul_b = ctl.mul_use_op ? operand : wb_q;

    gfi_bitser_mul #(.M(M), .POLY(POLY)) u_mul (
        .clk       (clk),
        .rst       (rst),
        .en        (ctl.mul_en),
        .first     (ctl.mul_first),
        .idx       (mul_idx),
        .a         (wa_q),
        .b         (mul_b),
        .prod_next (prod_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wa_q <= '0;
            wb_q <= '0;
        end else if (ctl.ld) begin
            wa_q <= operand;
            wb_q <= operand;
        end else if (ctl.sq_en) begin
            wa_q <= sq_y;
        end else if (ctl.mul_wr) begin
            wa_q <= prod_next;
            wb_q <= prod_next;
        end
    end

    assign result = wa_q;

endmodule

// File: rtl/gfi_inverter_chk.sv
module gfi_inverter_chk #(
    parameter int M = gfi_pkg::FIELD_M
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [M-1:0] operand,
    input logic [M-1:0] result,
    input logic         done,
    input logic         busy
);
    localparam int LAT = gfi_pkg::inv_latency(M);

    logic [31:0] cyc_q;
    logic        zero_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc_q  <= '0;
            zero_q <= 1'b0;
        end else if (start && !busy) begin
            cyc_q  <= '0;
            zero_q <= (operand == '0);
        end else if (busy) begin
            cyc_q <= cyc_q + 1;
        end
    end

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (cyc_q == LAT));

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R3
    zero_result_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(done) && zero_q) |-> (result == '0));

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(result)));

    // R6
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> !done);

    // R5
    busy_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> (busy || done));

endmodule

bind gfi_inverter gfi_inverter_chk #(.M(M)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .operand (operand),
    .result  (result),
    .done    (done),
    .busy    (busy)
);

// File: tb/sim_gfi_inverter.sv
module sim_gfi_inverter;
    localparam int CLK_PERIOD = 10;
    localparam int M          = 163;
    localparam int LAT        = (M - 1) + 9 * M;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [M-1:0] operand = '0;
    logic [M-1:0] result;
    logic         done;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gfi_inverter u0 (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .operand (operand),
        .result  (result),
        .done    (done)
    );

    // LSB-first shift-and-add product in the field
    function automatic logic [M-1:0] fmul(input logic [M-1:0] x, input logic [M-1:0] y);
        logic [M-1:0] r;
        logic [M-1:0] s;
        logic         top;
        r = '0;
        s = x;
        for (int i = 0; i < M; i++) begin
            if (y[i]) r = r ^ s;
            top = s[M-1];
            s   = s << 1;
            if (top) s = s ^ M'(8'hC9);
        end
        return r;
    endfunction

    function automatic logic [M-1:0] rnd_elem();
        logic [191:0] t;
        t = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        return t[M-1:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [M-1:0] act,
                         input logic [M-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // poke: negedge index after acceptance at which start is raised for one cycle (0 = never)
    task automatic run_inv(input logic [M-1:0] op, input int poke, input string tag);
        logic [M-1:0] held;
        @(negedge clk);
        operand = op;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, {"R6 done cleared ", tag}, M'(done), '0);
        for (int k = 1; k <= LAT; k++) begin
            @(negedge clk);
            start = (k == poke);
            if (k == LAT - 1) check(done == 1'b0, {"R2 done low before end ", tag}, M'(done), '0);
            if (k == LAT)     check(done == 1'b1, {"R2 done at latency ", tag}, M'(done), M'(1));
        end
        start = 1'b0;
        if (op == '0)
            check(result == '0, {"R3 zero operand ", tag}, result, '0);
        else
            check(fmul(op, result) == M'(1), {"R1 inverse product ", tag}, fmul(op, result), M'(1));
        held = result;
        repeat (4) @(negedge clk);
        check(done == 1'b1 && result == held, {"R4 hold ", tag}, result, held);
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7
        check(done == 1'b0, "R7 reset done", M'(done), '0);
        check(result == '0, "R7 reset result", result, '0);

        // R8 identity and all-ones
        run_inv(M'(1), 0, "one");
        check(result == M'(1), "R8 one maps to one", result, M'(1));
        run_inv({M{1'b1}}, 0, "R8 all-ones");

        // R1 directed: inverse of x
        run_inv(M'(2), 0, "x");
        check(result == ((M'(1) << 162) | M'(8'h64)), "R1 inverse of x", result,
              (M'(1) << 162) | M'(8'h64));

        // R3 zero operand
        run_inv('0, 0, "zero");

        // R5 start pulses during computation: mid-run and on the final edge
        run_inv(rnd_elem(), 300, "R5 mid");
        run_inv(rnd_elem(), LAT - 1, "R5 final edge");

        // random operands
        for (int n = 0; n < 8; n++) begin
            run_inv(rnd_elem(), 0, "random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule